// File: doc/BRIEF.md
# Single-Clock Streaming FIFO

This block is a first-in first-out buffer for one clock domain. Words enter through a valid/ready write stream and leave through a valid/ready read stream. They are held in a dual-port memory that is written on the clock edge and read combinationally at the read pointer. The memory depth is always a power of two, set by the address-width parameter `ADDR_W`.

One slot is always left empty, so a full buffer and an empty buffer can be told apart by comparing only the two pointers. The usable capacity is therefore `2**ADDR_W - 1` words. With the default `ADDR_W = 4`, that is 15 words.

Back-pressure rules:
- A word is written on a clock edge only when `in_valid` and `in_ready` are both high.
- A word is removed on a clock edge only when `out_valid` and `out_ready` are both high.
- `in_ready` is low exactly when the buffer holds its capacity.
- `out_valid` is low exactly when the buffer holds nothing.

There is no path from the write side straight to the read side. When the buffer is empty, a read request in the same cycle as a write is not a handshake, and only the write takes effect. Two outputs report how many words are held and how many slots are free.

Top module: `sfifo_top`

## Requirements
- R1: A synchronous active-high `rst` sampled on a clock edge empties the buffer. After it, `level` = 0, `free` = `2**ADDR_W-1`, `in_ready` = 1 and `out_valid` = 0.
- R2: Each write handshake that has no read handshake in the same cycle raises `level` by one after that edge.
- R3: The capacity is `2**ADDR_W-1` words. `in_ready` is low exactly when `level` equals that value.
- R4: `in_valid` asserted while `in_ready` is low has no effect. `level` does not change, and the word never appears at the read side.
- R5: `out_ready` asserted while `out_valid` is low has no effect. `level` stays 0 and no word is lost.
- R6: Words leave in exactly the order they were accepted, with no loss and no duplication.
- R7: After a write into an empty buffer, `out_valid` is 1 and `out_data` carries that word once the write edge has passed. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R8: A write handshake and a read handshake on the same edge, with the buffer neither empty nor full, leave `level` unchanged and keep the order.
- R9: A write and a read request on the same edge while empty result in only the write. `level` becomes 1, and the written word is presented at `out_data`.
- R10: A write and a read request on the same edge while full result in only the read, because `in_ready` is low. `level` drops by one, and the offered word is not stored.
- R11: `free` equals `2**ADDR_W-1` minus `level` at all times.
- R12: The pointers wrap modulo `2**ADDR_W`. Order and counts stay correct over long runs that pass many times through every memory slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word offered on the write stream |
| in_valid | input | 1 | Write stream has a word |
| in_ready | output | 1 | Buffer can accept a word |
| out_data | output | DATA_W | Oldest stored word |
| out_valid | output | 1 | Buffer holds at least one word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| level | output | ADDR_W | Number of stored words |
| free | output | ADDR_W | Number of free usable slots |

## Verification
The occupancy is kept twice: once as the difference between the two pointers, and once as a separate counter. A slip in either one shows up on the next edge as a mismatch between `free` and `level`, or between the ready/valid flags and `level`. A pointer that steps wrongly shows up at the read side as a word out of order, lost or repeated. For an overwrite, this appears when the affected word reaches the head, so the bench drains every fill completely and compares each word. Handshakes that should have been ignored while full or empty are checked through `level` on the very next cycle, and through the drained sequence afterwards.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Kind of occupancy change on one clock edge, encoded as {pop, push}
  typedef enum logic [1:0] {
    OCC_HOLD   = 2'b00,
    OCC_GROW   = 2'b01,
    OCC_SHRINK = 2'b10,
    OCC_SWAP   = 2'b11
  } occ_step_e;

  function automatic occ_step_e occ_classify(input logic push, input logic pop);
    return occ_step_e'({pop, push});
  endfunction

endpackage

// File: rtl/sfifo_ram.sv
// Dual-port storage: one clock, write on edge, combinational read
module sfifo_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sfifo_ptrs.sv
// Write and read pointers, full/empty flags and free-slot count from pointer distance
module sfifo_ptrs #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] free_slots
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] wr_next;
  logic [ADDR_W-1:0] rd_next;

  assign wr_next = wr_ptr + ONE;
  assign rd_next = rd_ptr + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_next;
      if (pop)  rd_ptr <= rd_next;
    end
  end

  assign empty      = (wr_ptr == rd_ptr);
  assign full       = (wr_next == rd_ptr);
  assign free_slots = rd_ptr - wr_ptr - ONE;
endmodule

// File: rtl/sfifo_level.sv
// Occupancy counter driven by the per-edge handshake pattern
module sfifo_level #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] count
);
  import sfifo_pkg::*;

  occ_step_e step;

  assign step = occ_classify(push, pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case (step)
        OCC_GROW:   count <= count + ADDR_W'(1);
        OCC_SHRINK: count <= count - ADDR_W'(1);
        default:    count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] level,
  output logic [ADDR_W-1:0] free
);
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic              full;
  logic              empty;
  logic              push;
  logic              pop;

  assign in_ready  = ~full;
  assign out_valid = ~empty;
  assign push      = in_valid & ~full;
  assign pop       = out_ready & ~empty;

  sfifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .pop        (pop),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .full       (full),
    .empty      (empty),
    .free_slots (free)
  );

  sfifo_level #(.ADDR_W(ADDR_W)) u_level (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .count (level)
  );

  sfifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .wr_en   (push),
    .wr_addr (wr_ptr),
    .wr_data (in_data),
    .rd_addr (rd_ptr),
    .rd_data (out_data)
  );
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] level,
  input logic [ADDR_W-1:0] free
);
  localparam logic [ADDR_W-1:0] CAP = ADDR_W'((1 << ADDR_W) - 1);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      assert_reset_clear_R1: assert (level == '0 && !out_valid && in_ready)
        else $error("reset did not empty the buffer");
    end
  end

  assert_ready_full_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready == (level != CAP));

  assert_valid_empty_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid == (level != '0));

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> level == $past(level) + ADDR_W'(1));

  assert_swap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_valid && out_ready) |=> $stable(level));

  assert_full_block_R4: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !out_ready) |=> $stable(level));

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_free_sum_R11: assert property (@(posedge clk) disable iff (rst)
    (ADDR_W + 1)'(free) + (ADDR_W + 1)'(level) == (ADDR_W + 1)'(CAP));
endmodule

bind sfifo_top sfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .level     (level),
  .free      (free)
);

// File: tb/sim_sfifo_top.sv
module sim_sfifo_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int CAP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] level;
  logic [AW-1:0] free;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfifo_top #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .level(level), .free(free)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts and flags against the reference queue
  task automatic check_state(input string req);
    check({req, " level"}, int'(level), model.size());
    check({req, " free"}, int'(free), CAP - model.size());
    check({req, " in_ready"}, int'(in_ready), (model.size() < CAP) ? 1 : 0);
    check({req, " out_valid"}, int'(out_valid), (model.size() > 0) ? 1 : 0);
  endtask

  // One clock: offer inputs, predict handshakes from the reference, update after the edge
  task automatic step(input bit iv, input logic [DW-1:0] d, input bit ordy);
    bit do_push;
    bit do_pop;
    do_push = iv && (model.size() < CAP);
    do_pop  = ordy && (model.size() > 0);
    in_valid  = iv;
    in_data   = d;
    out_ready = ordy;
    if (do_pop) check("R6 head word", int'(out_data), int'(model[0]));
    @(posedge clk);
    #1;
    if (do_pop) void'(model.pop_front());
    if (do_push) model.push_back(d);
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) step(1'b0, '0, 1'b1);
    check_state(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    model.delete();
    check_state("R1");
  endtask

  task automatic t_fill_full;
    for (int i = 0; i < CAP; i++) begin
      step(1'b1, DW'(8'h10 + i), 1'b0);
      check("R2 level", int'(level), i + 1);
      check("R11 free", int'(free), CAP - i - 1);
    end
    check("R3 in_ready at capacity", int'(in_ready), 0);
    check_state("R3");
  endtask

  task automatic t_overflow;
    step(1'b1, 8'hEE, 1'b0);
    check("R4 level unchanged", int'(level), CAP);
    step(1'b1, 8'hEF, 1'b0);
    check_state("R4");
    drain("R4");
  endtask

  task automatic t_empty_read;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b1);
      check("R5 level", int'(level), 0);
      check("R5 out_valid", int'(out_valid), 0);
    end
    step(1'b1, 8'h5A, 1'b0);
    check("R7 out_valid after write", int'(out_valid), 1);
    check("R7 out_data after write", int'(out_data), 8'h5A);
    step(1'b1, 8'h5B, 1'b0);
    step(1'b0, '0, 1'b0);
    check("R7 head held", int'(out_data), 8'h5A);
    drain("R6");
  endtask

  task automatic t_swap_mid;
    for (int i = 0; i < 3; i++) step(1'b1, DW'(8'h30 + i), 1'b0);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, DW'(8'h40 + i), 1'b1);
      check("R8 level steady", int'(level), 3);
    end
    drain("R8");
  endtask

  task automatic t_swap_empty;
    step(1'b1, 8'hA7, 1'b1);
    check("R9 level", int'(level), 1);
    check("R9 out_data", int'(out_data), 8'hA7);
    drain("R9");
  endtask

  task automatic t_swap_full;
    for (int i = 0; i < CAP; i++) step(1'b1, DW'(8'h60 + i), 1'b0);
    step(1'b1, 8'hCC, 1'b1);
    check("R10 level", int'(level), CAP - 1);
    check_state("R10");
    drain("R10");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 200; i++) begin
      step((i % 3) != 0, DW'(i * 7 + 3), (i % 2) == 0 || (i % 5) == 1);
    end
    check_state("R12");
    drain("R12");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_full();
    t_overflow();
    t_empty_read();
    t_swap_mid();
    t_swap_empty();
    t_swap_full();
    t_wrap();
    for (int i = 0; i < 5; i++) step(1'b1, DW'(i), 1'b0);
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule